// File: doc/BRIEF.md
# Debug Breakpoint and Trace Unit

This unit sits beside the retirement stage of a simple in-order core. For every retiring instruction it sees a record with the program counter, the data effective address, the access type, the instruction class and a valid flag. From those records and its configuration inputs it decides whether the core must take a debug exception, and which vector offset to use. The configuration inputs are two instruction-address compare registers, two data-address compare registers, a single-step enable, a branch-trace enable and a halt-mode enable.

There are two breakpoint kinds. An instruction-address breakpoint holds the flagged instruction back from retiring until the handler acknowledges. A data-address breakpoint does the same. Trace exceptions are raised after the instruction completes, and retirement is not held. When halt mode is enabled together with single-step, the unit stops the core before the instruction retires, in place of a trace exception.

The controller has four states. ST_IDLE accepts records. ST_BRK_WAIT follows a breakpoint and keeps retirement held. ST_TRC_WAIT follows a trace request. ST_HALTED keeps the core stopped. From ST_IDLE the unit moves to ST_HALTED on a halt hit, to ST_BRK_WAIT on a breakpoint hit, or to ST_TRC_WAIT on a trace hit. Any of the three waiting states returns to ST_IDLE when `exc_ack` is high.

Top module: `dbg_trap_unit`

## Requirements
- R1: The response to a record appears one cycle after the record is sampled. A valid record that hits an enabled instruction-address compare register gives a one-cycle `exc_req` with `exc_vec` = 0x01300, and raises `retire_hold`.
- R2: Each compare register has a 2-bit condition: 0 = address equal to the register, 1 = address less than the register, 2 = address greater than or equal to the register, 3 = never matches.
- R3: When the pair bit of a source is set, that source hits only if both of its registers are enabled and both match. This gives a range match. When the pair bit is clear, any enabled register that matches gives a hit.
- R4: The access type is encoded as 0 = none, 1 = read, 2 = write. Each data register has a read-enable and a write-enable. A register counts only when the enable for the record's access type is set. A data hit gives `exc_vec` = 0x00300 and raises `retire_hold`.
- R5: When single-step is on and halt mode is off, every valid record outside the suppressed classes gives `exc_vec` = 0x00D00, and `retire_hold` stays low.
- R6: Branch-trace raises the 0x00D00 request only for records of class 1 (branch). Other classes give no request.
- R7: Classes 2 (instruction synchronize), 3 (memory sync), 4 (interrupt return), 5 (critical interrupt return) and 6 (machine-state write) never raise a single-step trace. Class 0 is a plain instruction.
- R8: When single-step and halt mode are both on, a valid record raises `halt_req` and `retire_hold` one cycle later, and `exc_req` stays low.
- R9: When several sources fire together, the order is halt first, then the instruction breakpoint, then the data breakpoint, then trace. Exactly one outcome is issued for each record.
- R10: `exc_req` lasts a single cycle. `exc_vec` carries the vector during that cycle and is zero at all other times.
- R11: While an outcome is pending, new records are ignored. An `exc_ack` returns the unit to idle and drops `retire_hold` and `halt_req` one cycle later.
- R12: After reset, `exc_req`, `exc_vec`, `halt_req` and `retire_hold` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | Retirement record valid |
| ret_pc | input | AW | Instruction address of the record |
| ret_ea | input | AW | Data effective address of the record |
| ret_acc | input | 2 | Access type (0 none, 1 read, 2 write) |
| ret_cls | input | 3 | Instruction class code |
| ia_ref | input | 2*AW | Instruction compare registers, register 0 in the low half |
| ia_cond | input | 4 | Condition codes of the instruction registers, 2 bits each |
| ia_en | input | 2 | Enables of the instruction registers |
| ia_pair | input | 1 | Range mode for the instruction registers |
| da_ref | input | 2*AW | Data compare registers, register 0 in the low half |
| da_cond | input | 4 | Condition codes of the data registers |
| da_rd_en | input | 2 | Read enables of the data registers |
| da_wr_en | input | 2 | Write enables of the data registers |
| da_pair | input | 1 | Range mode for the data registers |
| step_en | input | 1 | Single-step enable |
| brtrace_en | input | 1 | Branch-trace enable |
| halt_mode_en | input | 1 | Halt (stop) mode enable |
| exc_ack | input | 1 | Handler return or resume from the core |
| exc_req | output | 1 | One-cycle exception request |
| exc_vec | output | 20 | Vector offset, valid while exc_req is high |
| halt_req | output | 1 | Stop request to the core |
| retire_hold | output | 1 | Hold the flagged instruction from retiring |

## Verification
The assertions check the following on every cycle:
- the pulse shape of the request, and that the vector is legal and zero outside the pulse;
- that a halt never occurs together with a request and has a matching cause one cycle earlier;
- that breakpoint vectors come with the retire hold and trace vectors without it;
- that no request is issued while a hold persists, and that an acknowledge releases the hold.

Only the bench scenarios can show that the right source wins. This covers the compare conditions, range pairing, the read and write qualification, class suppression and the priority between simultaneous hits. The bench checks these against a reference function over random configurations and directed corner cases.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;

    typedef enum logic [1:0] {
        CMP_EQ  = 2'd0,
        CMP_LT  = 2'd1,
        CMP_GE  = 2'd2,
        CMP_OFF = 2'd3
    } cmp_kind_e;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        CLS_PLAIN  = 3'd0,
        CLS_BRANCH = 3'd1,
        CLS_ISYNC  = 3'd2,
        CLS_MSYNC  = 3'd3,
        CLS_IRET   = 3'd4,
        CLS_CIRET  = 3'd5,
        CLS_MSWR   = 3'd6,
        CLS_RSVD   = 3'd7
    } ins_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_BRK_WAIT = 2'd1,
        ST_TRC_WAIT = 2'd2,
        ST_HALTED   = 2'd3
    } trap_state_e;

    localparam int VEC_W = 20;
    localparam logic [VEC_W-1:0] VEC_IBRK  = 20'h01300;
    localparam logic [VEC_W-1:0] VEC_DBRK  = 20'h00300;
    localparam logic [VEC_W-1:0] VEC_TRACE = 20'h00D00;

endpackage

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp
    import dbg_trap_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ref_addr,
    input  logic [1:0]    kind,
    output logic          hit
);

    always_comb begin
        unique case (cmp_kind_e'(kind))
            CMP_EQ:  hit = (addr == ref_addr);
            CMP_LT:  hit = (addr <  ref_addr);
            CMP_GE:  hit = (addr >= ref_addr);
            CMP_OFF: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/dbg_bp_source.sv
module dbg_bp_source #(
    parameter int AW   = 32,
    parameter int NREG = 2
) (
    input  logic [AW-1:0]      addr,
    input  logic [NREG*AW-1:0] refs,
    input  logic [2*NREG-1:0]  kinds,
    input  logic [NREG-1:0]    reg_en,
    input  logic               pair_mode,
    output logic               hit
);

    logic [NREG-1:0] raw_match;
    logic [NREG-1:0] qual_match;

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        dbg_addr_cmp #(.AW(AW)) u_cmp (
            .addr     (addr),
            .ref_addr (refs[g*AW +: AW]),
            .kind     (kinds[2*g +: 2]),
            .hit      (raw_match[g])
        );
    end

    assign qual_match = raw_match & reg_en;

    always_comb begin
        if (pair_mode) hit = &qual_match;
        else           hit = |qual_match;
    end

endmodule

// File: rtl/dbg_trace_filter.sv
module dbg_trace_filter
    import dbg_trap_pkg::*;
(
    input  logic       rec_valid,
    input  logic [2:0] rec_cls,
    input  logic       step_en,
    input  logic       brtrace_en,
    input  logic       halt_mode_en,
    output logic       halt_hit,
    output logic       trace_hit
);

    logic step_quiet;
    logic is_branch;

    always_comb begin
        unique case (ins_cls_e'(rec_cls))
            CLS_ISYNC, CLS_MSYNC, CLS_IRET, CLS_CIRET, CLS_MSWR: step_quiet = 1'b1;
            default:                                             step_quiet = 1'b0;
        endcase
    end

    assign is_branch = (ins_cls_e'(rec_cls) == CLS_BRANCH);
    assign halt_hit  = rec_valid && step_en && halt_mode_en;
    assign trace_hit = rec_valid && !halt_hit &&
                       ((step_en && !step_quiet) || (brtrace_en && is_branch));

endmodule

// File: rtl/dbg_trap_unit.sv
module dbg_trap_unit
    import dbg_trap_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic [AW-1:0]     ret_pc,
    input  logic [AW-1:0]     ret_ea,
    input  logic [1:0]        ret_acc,
    input  logic [2:0]        ret_cls,
    input  logic [2*AW-1:0]   ia_ref,
    input  logic [3:0]        ia_cond,
    input  logic [1:0]        ia_en,
    input  logic              ia_pair,
    input  logic [2*AW-1:0]   da_ref,
    input  logic [3:0]        da_cond,
    input  logic [1:0]        da_rd_en,
    input  logic [1:0]        da_wr_en,
    input  logic              da_pair,
    input  logic              step_en,
    input  logic              brtrace_en,
    input  logic              halt_mode_en,
    input  logic              exc_ack,
    output logic              exc_req,
    output logic [19:0]       exc_vec,
    output logic              halt_req,
    output logic              retire_hold
);

    localparam int NREG = 2;

    logic [NREG-1:0]  da_reg_en;
    logic             ia_src_hit, da_src_hit;
    logic             ia_hit, da_hit, halt_hit, trace_hit;
    trap_state_e      state_q, state_d;
    logic             req_d;
    logic [VEC_W-1:0] vec_d;
    logic             req_q, halt_q, hold_q;
    logic [VEC_W-1:0] vec_q;

    for (genvar g = 0; g < NREG; g++) begin : g_den
        assign da_reg_en[g] = (acc_kind_e'(ret_acc) == ACC_READ  && da_rd_en[g]) ||
                              (acc_kind_e'(ret_acc) == ACC_WRITE && da_wr_en[g]);
    end

    dbg_bp_source #(.AW(AW), .NREG(NREG)) u_isrc (
        .addr      (ret_pc),
        .refs      (ia_ref),
        .kinds     (ia_cond),
        .reg_en    (ia_en),
        .pair_mode (ia_pair),
        .hit       (ia_src_hit)
    );

    dbg_bp_source #(.AW(AW), .NREG(NREG)) u_dsrc (
        .addr      (ret_ea),
        .refs      (da_ref),
        .kinds     (da_cond),
        .reg_en    (da_reg_en),
        .pair_mode (da_pair),
        .hit       (da_src_hit)
    );

    dbg_trace_filter u_trc (
        .rec_valid    (ret_valid),
        .rec_cls      (ret_cls),
        .step_en      (step_en),
        .brtrace_en   (brtrace_en),
        .halt_mode_en (halt_mode_en),
        .halt_hit     (halt_hit),
        .trace_hit    (trace_hit)
    );

    assign ia_hit = ret_valid && ia_src_hit;
    assign da_hit = ret_valid && da_src_hit;

    // next state and the outcome of the current record
    always_comb begin
        state_d = state_q;
        req_d   = 1'b0;
        vec_d   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (halt_hit) begin
                    state_d = ST_HALTED;
                end else if (ia_hit) begin
                    state_d = ST_BRK_WAIT;
                    req_d   = 1'b1;
                    vec_d   = VEC_IBRK;
                end else if (da_hit) begin
                    state_d = ST_BRK_WAIT;
                    req_d   = 1'b1;
                    vec_d   = VEC_DBRK;
                end else if (trace_hit) begin
                    state_d = ST_TRC_WAIT;
                    req_d   = 1'b1;
                    vec_d   = VEC_TRACE;
                end
            end
            ST_BRK_WAIT, ST_TRC_WAIT, ST_HALTED: begin
                if (exc_ack) state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            vec_q  <= '0;
            halt_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            req_q  <= req_d;
            vec_q  <= vec_d;
            halt_q <= (state_d == ST_HALTED);
            hold_q <= (state_d == ST_HALTED) || (state_d == ST_BRK_WAIT);
        end
    end

    assign exc_req     = req_q;
    assign exc_vec     = vec_q;
    assign halt_req    = halt_q;
    assign retire_hold = hold_q;

endmodule

// File: rtl/dbg_trap_chk.sv
module dbg_trap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ret_valid,
    input logic        step_en,
    input logic        halt_mode_en,
    input logic        exc_ack,
    input logic        exc_req,
    input logic [19:0] exc_vec,
    input logic        halt_req,
    input logic        retire_hold
);

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> !exc_req);  // R10

    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (exc_vec == 20'h01300 || exc_vec == 20'h00300 || exc_vec == 20'h00D00));  // R10

    AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |-> (exc_vec == 20'h0));  // R10

    AST_HALT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> !exc_req);  // R8

    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) |-> $past(ret_valid && step_en && halt_mode_en));  // R8

    AST_BRK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_vec != 20'h00D00) |-> retire_hold);  // R1

    AST_TRACE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_vec == 20'h00D00) |-> !retire_hold);  // R5

    AST_REQ_HAS_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> $past(ret_valid));  // R9

    AST_PENDING_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_hold && $past(retire_hold)) |-> !exc_req);  // R11

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_ack && retire_hold) |=> (!retire_hold && !halt_req));  // R11

endmodule

bind dbg_trap_unit dbg_trap_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ret_valid    (ret_valid),
    .step_en      (step_en),
    .halt_mode_en (halt_mode_en),
    .exc_ack      (exc_ack),
    .exc_req      (exc_req),
    .exc_vec      (exc_vec),
    .halt_req     (halt_req),
    .retire_hold  (retire_hold)
);

// File: tb/sim_dbg_trap_unit.sv
module sim_dbg_trap_unit;

    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ret_valid = 1'b0;
    logic [AW-1:0] ret_pc = '0, ret_ea = '0;
    logic [1:0] ret_acc = '0;
    logic [2:0] ret_cls = '0;
    logic [2*AW-1:0] ia_ref = '0, da_ref = '0;
    logic [3:0] ia_cond = '0, da_cond = '0;
    logic [1:0] ia_en = '0, da_rd_en = '0, da_wr_en = '0;
    logic ia_pair = 1'b0, da_pair = 1'b0;
    logic step_en = 1'b0, brtrace_en = 1'b0, halt_mode_en = 1'b0;
    logic exc_ack = 1'b0;
    logic exc_req, halt_req, retire_hold;
    logic [19:0] exc_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dbg_trap_unit #(.AW(AW)) u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit cmp_f(input logic [AW-1:0] a, input logic [AW-1:0] r, input logic [1:0] k);
        case (k)
            2'd0: return a == r;
            2'd1: return a < r;
            2'd2: return a >= r;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit src_f(input logic [AW-1:0] a, input logic [2*AW-1:0] r,
                                 input logic [3:0] k, input logic [1:0] en, input logic pr);
        bit m0, m1;
        m0 = en[0] && cmp_f(a, r[AW-1:0], k[1:0]);
        m1 = en[1] && cmp_f(a, r[2*AW-1:AW], k[3:2]);
        return pr ? (m0 && m1) : (m0 || m1);
    endfunction

    // outcome codes: 0 none, 1 halt, 2 ibrk, 3 dbrk, 4 trace
    function automatic int expect_f();
        logic [1:0] den;
        bit quiet;
        den[0] = (ret_acc == 2'd1 && da_rd_en[0]) || (ret_acc == 2'd2 && da_wr_en[0]);
        den[1] = (ret_acc == 2'd1 && da_rd_en[1]) || (ret_acc == 2'd2 && da_wr_en[1]);
        quiet = (ret_cls >= 3'd2 && ret_cls <= 3'd6);
        if (step_en && halt_mode_en) return 1;
        if (src_f(ret_pc, ia_ref, ia_cond, ia_en, ia_pair)) return 2;
        if (src_f(ret_ea, da_ref, da_cond, den, da_pair)) return 3;
        if ((step_en && !quiet) || (brtrace_en && ret_cls == 3'd1)) return 4;
        return 0;
    endfunction

    function automatic logic [19:0] vec_f(input int o);
        case (o)
            2: return 20'h01300;
            3: return 20'h00300;
            4: return 20'h00D00;
            default: return 20'h0;
        endcase
    endfunction

    task automatic clear_cfg();
        ia_ref = '0; da_ref = '0; ia_cond = 4'hF; da_cond = 4'hF;
        ia_en = '0; da_rd_en = '0; da_wr_en = '0; ia_pair = 0; da_pair = 0;
        step_en = 0; brtrace_en = 0; halt_mode_en = 0;
        ret_pc = '0; ret_ea = '0; ret_acc = '0; ret_cls = '0;
    endtask

    // present one record (inputs already set), check outcome, then drain
    task automatic run_rec(input string req);
        int o;
        o = expect_f();
        @(negedge clk); ret_valid = 1'b1;
        @(negedge clk); ret_valid = 1'b0;
        check({req, " req"},  exc_req,     (o >= 2) ? 1 : 0);
        check({req, " vec"},  exc_vec,     vec_f(o));
        check({req, " halt"}, halt_req,    (o == 1) ? 1 : 0);
        check({req, " hold"}, retire_hold, (o == 1 || o == 2 || o == 3) ? 1 : 0);
        if (o != 0) begin
            ret_valid = 1'b1;              // ignored while pending
            @(negedge clk); ret_valid = 1'b0;
            check("R10 pulse ends", exc_req, 0);
            check("R10 vec cleared", exc_vec, 0);
            @(negedge clk);
            check("R11 ignored while pending", exc_req, 0);
            exc_ack = 1'b1;
            @(negedge clk); exc_ack = 1'b0;
            check("R11 hold released", retire_hold, 0);
            check("R11 halt released", halt_req, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        clear_cfg();
        repeat (3) @(negedge clk);
        check("R12 req at reset", exc_req, 0);
        check("R12 vec at reset", exc_vec, 0);
        check("R12 halt at reset", halt_req, 0);
        check("R12 hold at reset", retire_hold, 0);
        rst_n = 1'b1;

        // R1 equal instruction match
        clear_cfg(); ia_en = 2'b01; ia_cond = 4'b1100; ia_ref[AW-1:0] = 32'h200; ret_pc = 32'h200;
        run_rec("R1 ibrk eq");
        // R2 less-than and greater-equal, and never
        ret_pc = 32'h1FC; ia_cond = 4'b1101; run_rec("R2 lt hit");
        ret_pc = 32'h200; run_rec("R2 lt miss");
        ia_cond = 4'b1110; run_rec("R2 ge hit");
        ia_cond = 4'b1111; run_rec("R2 never");
        // R3 range pair
        clear_cfg(); ia_en = 2'b11; ia_pair = 1; ia_cond = 4'b0110;
        ia_ref = {32'h300, 32'h100};
        ret_pc = 32'h180; run_rec("R3 in range");
        ret_pc = 32'h300; run_rec("R3 above range");
        ia_en = 2'b01; ret_pc = 32'h180; run_rec("R3 pair needs both");
        // R4 data read/write
        clear_cfg(); da_cond = 4'b1100; da_ref[AW-1:0] = 32'h40; ret_ea = 32'h40;
        da_rd_en = 2'b01; ret_acc = 2'd1; run_rec("R4 read hit");
        ret_acc = 2'd2; run_rec("R4 write not enabled");
        da_wr_en = 2'b01; run_rec("R4 write hit");
        ret_acc = 2'd0; run_rec("R4 no access");
        // R5 / R7 single step over classes
        clear_cfg(); step_en = 1;
        for (int c = 0; c < 8; c++) begin
            ret_cls = 3'(c);
            run_rec((c >= 2 && c <= 6) ? "R7 suppressed class" : "R5 step trace");
        end
        // R6 branch trace
        clear_cfg(); brtrace_en = 1;
        ret_cls = 3'd1; run_rec("R6 branch");
        ret_cls = 3'd0; run_rec("R6 non-branch");
        // R8 halt overrides step
        clear_cfg(); step_en = 1; halt_mode_en = 1; run_rec("R8 halt");
        // R9 priority
        clear_cfg(); ia_en = 2'b01; ia_cond = 4'b1100; da_rd_en = 2'b01; da_cond = 4'b1100;
        ret_acc = 2'd1; step_en = 1; run_rec("R9 ibrk over dbrk/trace");
        ia_en = 2'b00; run_rec("R9 dbrk over trace");
        halt_mode_en = 1; ia_en = 2'b01; run_rec("R9 halt over all");

        // random mix
        for (int i = 0; i < 400; i++) begin
            ia_ref = {32'h100 + 32'(($urandom % 16) * 4), 32'h100 + 32'(($urandom % 16) * 4)};
            da_ref = {32'h100 + 32'(($urandom % 16) * 4), 32'h100 + 32'(($urandom % 16) * 4)};
            ia_cond = 4'($urandom); da_cond = 4'($urandom);
            ia_en = 2'($urandom); da_rd_en = 2'($urandom); da_wr_en = 2'($urandom);
            ia_pair = 1'($urandom); da_pair = 1'($urandom);
            step_en = ($urandom % 4) == 0; brtrace_en = 1'($urandom);
            halt_mode_en = ($urandom % 4) == 0;
            ret_pc = 32'h100 + 32'(($urandom % 16) * 4);
            ret_ea = 32'h100 + 32'(($urandom % 16) * 4);
            ret_acc = 2'($urandom); ret_cls = 3'($urandom);
            run_rec("R9 random");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule